// File: doc/BRIEF.md
# Configurable Slice Storage Element Array

This block models the eight storage elements of one logic slice: four primary elements (A, B, C, D) and four secondary elements (A5, B5, C5, D5). All eight share one element clock, one clock enable and one set/reset input. Each element has its own data input and output. Static configuration inputs set the behaviour. Slice-wide bits choose flip-flop or latch operation, synchronous or asynchronous set/reset, and clock polarity, and whether the clock enable and set/reset inputs are honoured at all. Per-element bits choose the value loaded at global initialisation and the value forced by set/reset.

The model runs on a fast system clock `clk`. It samples the element clock `ck_in` and the other slice inputs as ordinary data on every `clk` edge. Edge-triggered behaviour is detected from two consecutive samples. Level-sensitive and asynchronous behaviour acts on any sample. Every result is registered, so it appears on `q` one `clk` cycle after the inputs that caused it. `ck_in` is expected to stay stable for at least one `clk` period between changes.

Bit ordering is the same on `d`, `q`, `cfg_init_sel` and `cfg_rst_zero`. Bits 0..N_PRI-1 are the primary elements A..D in order. Bits N_PRI..2*N_PRI-1 are the matching secondary elements.

Top module: `slice_store_array`

## Requirements
- R1: While `glob_init` is 1, every element loads its init value on the next `clk` edge. In flip-flop mode, `cfg_init_sel` bit 0 gives 1 and bit 1 gives 0. In latch mode, bit 0 gives 0 and bit 1 gives 1.
- R2: In flip-flop mode, an active clock edge is a sample where `ck_in XOR cfg_ck_inv` is 1 and was 0 on the previous sample. Without set/reset and with the enable met, an element takes `d` on that edge, and holds otherwise.
- R3: In latch mode, a primary element is transparent while `ck_in` equals `cfg_ck_inv`. With `cfg_ck_inv`=1 it is transparent while `ck_in` is high; with 0, while `ck_in` is low. When transparent and enabled it follows `d`; otherwise it holds.
- R4: In latch mode, the secondary outputs are 0.
- R5: Set/reset drives an element to 0 when its `cfg_rst_zero` bit is 1, and to 1 when that bit is 0.
- R6: With `cfg_sync_sr`=0, or in latch mode, an active set/reset acts on any sample. It overrides the clock, the enable and the data.
- R7: In flip-flop mode with `cfg_sync_sr`=1, set/reset acts only at an active clock edge where the enable is met. Otherwise the element holds.
- R8: With `cfg_ce_used`=0, `ce_in` is ignored and the enable counts as met. With 1, `ce_in`=0 blocks loads and synchronous set/reset.
- R9: With `cfg_sr_used`=0, `sr_in` has no effect in any mode.
- R10: `glob_init` takes priority over set/reset, and set/reset takes priority over data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| glob_init | input | 1 | Global initialise, synchronous active-high |
| cfg_latch | input | 1 | 1: primaries are latches and secondaries are off |
| cfg_sync_sr | input | 1 | 1: synchronous set/reset in flip-flop mode |
| cfg_ck_inv | input | 1 | Clock polarity bit (meaning depends on mode) |
| cfg_ce_used | input | 1 | 1: honour ce_in |
| cfg_sr_used | input | 1 | 1: honour sr_in |
| cfg_init_sel | input | 2*N_PRI | Per-element init select |
| cfg_rst_zero | input | 2*N_PRI | Per-element set/reset value select |
| ck_in | input | 1 | Shared element clock / gate |
| ce_in | input | 1 | Shared clock enable |
| sr_in | input | 1 | Shared set/reset |
| d | input | 2*N_PRI | Element data inputs |
| q | output | 2*N_PRI | Element outputs |

## Verification
Every result is due exactly one `clk` cycle after the sample that caused it. This covers the init load, a flip-flop capture at a detected edge, latch transparency, asynchronous set/reset and the forced zero on the secondaries. The bench drives the inputs on the falling edge of `clk`. It advances its reference model by one step for those inputs and compares all of `q` 1 ns after the following rising edge. Clock-edge detection depends on the previous sample, so the reference model keeps its own copy of the previous effective clock level. The bench never changes `ck_in` faster than once per `clk` cycle.

// File: rtl/slice_store_pkg.sv
package slice_store_pkg;

    // Slice-wide static mode bits
    typedef struct packed {
        logic latch_mode;
        logic sync_sr;
        logic ck_inv;
        logic ce_used;
        logic sr_used;
    } slice_mode_t;

    // How set/reset is applied in the current mode
    typedef enum logic [1:0] {
        SR_ASYNC_FF = 2'd0,
        SR_SYNC_FF  = 2'd1,
        SR_LATCH    = 2'd2
    } sr_style_t;

    // Per-cycle controls broadcast to every element
    typedef struct packed {
        logic init_now;
        logic sr_apply;
        logic load;
        logic latch_mode;
    } elem_ctl_t;

    // Init value: the select bit is inverted for flip-flops only
    function automatic logic init_level(input logic latch_mode, input logic sel);
        return latch_mode ? sel : ~sel;
    endfunction

    // Set/reset value: rst_zero=1 clears, 0 presets
    function automatic logic sr_level(input logic rst_zero);
        return ~rst_zero;
    endfunction

endpackage

// File: rtl/slice_store_ctrl.sv
module slice_store_ctrl
    import slice_store_pkg::*;
(
    input  logic        clk,
    input  logic        glob_init,
    input  slice_mode_t mode,
    input  logic        ck_in,
    input  logic        ce_in,
    input  logic        sr_in,
    output elem_ctl_t   ctl
);
    logic      eff_ck;
    logic      eff_prev;
    logic      rise;
    logic      gate_open;
    logic      ce_ok;
    logic      sr_req;
    sr_style_t style;

    always_comb begin
        eff_ck    = ck_in ^ mode.ck_inv;
        rise      = eff_ck & ~eff_prev;
        // Latch polarity is the opposite sense of the flip-flop one
        gate_open = ~eff_ck;
        ce_ok     = ~mode.ce_used | ce_in;
        sr_req    = mode.sr_used & sr_in;
        if (mode.latch_mode)
            style = SR_LATCH;
        else if (mode.sync_sr)
            style = SR_SYNC_FF;
        else
            style = SR_ASYNC_FF;
    end

    always_ff @(posedge clk) begin
        eff_prev <= eff_ck;
    end

    always_comb begin
        ctl.init_now   = glob_init;
        ctl.latch_mode = mode.latch_mode;
        case (style)
            SR_LATCH: begin
                ctl.sr_apply = sr_req;
                ctl.load     = gate_open & ce_ok & ~sr_req;
            end
            SR_SYNC_FF: begin
                ctl.sr_apply = sr_req & rise & ce_ok;
                ctl.load     = rise & ce_ok & ~sr_req;
            end
            default: begin
                ctl.sr_apply = sr_req;
                ctl.load     = rise & ce_ok & ~sr_req;
            end
        endcase
    end

endmodule

// File: rtl/slice_store_elem.sv
module slice_store_elem
    import slice_store_pkg::*;
#(
    parameter bit SECONDARY = 1'b0
) (
    input  logic      clk,
    input  elem_ctl_t ctl,
    input  logic      init_sel,
    input  logic      rst_zero,
    input  logic      d,
    output logic      q
);
    logic disabled;

    always_comb disabled = SECONDARY && ctl.latch_mode;

    always_ff @(posedge clk) begin
        if (disabled)
            q <= 1'b0;
        else if (ctl.init_now)
            q <= init_level(ctl.latch_mode, init_sel);
        else if (ctl.sr_apply)
            q <= sr_level(rst_zero);
        else if (ctl.load)
            q <= d;
    end

endmodule

// File: rtl/slice_store_array.sv
module slice_store_array
    import slice_store_pkg::*;
#(
    parameter int N_PRI = 4
) (
    input  logic               clk,
    input  logic               glob_init,
    input  logic               cfg_latch,
    input  logic               cfg_sync_sr,
    input  logic               cfg_ck_inv,
    input  logic               cfg_ce_used,
    input  logic               cfg_sr_used,
    input  logic [2*N_PRI-1:0] cfg_init_sel,
    input  logic [2*N_PRI-1:0] cfg_rst_zero,
    input  logic               ck_in,
    input  logic               ce_in,
    input  logic               sr_in,
    input  logic [2*N_PRI-1:0] d,
    output logic [2*N_PRI-1:0] q
);
    localparam int N_ELEM = 2 * N_PRI;

    slice_mode_t mode;
    elem_ctl_t   ctl;

    always_comb begin
        mode.latch_mode = cfg_latch;
        mode.sync_sr    = cfg_sync_sr;
        mode.ck_inv     = cfg_ck_inv;
        mode.ce_used    = cfg_ce_used;
        mode.sr_used    = cfg_sr_used;
    end

    slice_store_ctrl u_ctrl (
        .clk       (clk),
        .glob_init (glob_init),
        .mode      (mode),
        .ck_in     (ck_in),
        .ce_in     (ce_in),
        .sr_in     (sr_in),
        .ctl       (ctl)
    );

    for (genvar i = 0; i < N_ELEM; i++) begin : g_elem
        slice_store_elem #(
            .SECONDARY (i >= N_PRI)
        ) u_elem (
            .clk      (clk),
            .ctl      (ctl),
            .init_sel (cfg_init_sel[i]),
            .rst_zero (cfg_rst_zero[i]),
            .d        (d[i]),
            .q        (q[i])
        );
    end

endmodule

// File: rtl/slice_store_chk.sv
module slice_store_chk #(
    parameter int N_PRI = 4
) (
    input logic               clk,
    input logic               glob_init,
    input logic               cfg_latch,
    input logic               cfg_sync_sr,
    input logic               cfg_ck_inv,
    input logic               cfg_ce_used,
    input logic               cfg_sr_used,
    input logic [2*N_PRI-1:0] cfg_rst_zero,
    input logic               ck_in,
    input logic               ce_in,
    input logic               sr_in,
    input logic [2*N_PRI-1:0] d,
    input logic [2*N_PRI-1:0] q
);
    localparam int N_ELEM = 2 * N_PRI;

    logic ck_seen = 1'b0;
    logic ck_last = 1'b0;

    always_ff @(posedge clk) begin
        ck_seen <= 1'b1;
        ck_last <= ck_in ^ cfg_ck_inv;
    end

    // R4
    secondary_off_chk: assert property (@(posedge clk) disable iff (glob_init)
        cfg_latch |=> (q[N_ELEM-1:N_PRI] == '0));

    // R8
    ce_hold_chk: assert property (@(posedge clk) disable iff (glob_init)
        (!cfg_latch && cfg_ce_used && !ce_in && !cfg_sr_used) |=> $stable(q));

    // R6
    async_sr_chk: assert property (@(posedge clk) disable iff (glob_init)
        (cfg_sr_used && sr_in && (cfg_latch || !cfg_sync_sr))
        |=> (q[N_PRI-1:0] == ~$past(cfg_rst_zero[N_PRI-1:0])));

    // R7
    sync_idle_chk: assert property (@(posedge clk) disable iff (glob_init)
        (ck_seen && !cfg_latch && cfg_sync_sr && !((ck_in ^ cfg_ck_inv) && !ck_last))
        |=> $stable(q));

    // R3
    latch_pass_chk: assert property (@(posedge clk) disable iff (glob_init)
        (cfg_latch && (ck_in == cfg_ck_inv) && (!cfg_ce_used || ce_in) && !(cfg_sr_used && sr_in))
        |=> (q[N_PRI-1:0] == $past(d[N_PRI-1:0])));

endmodule

bind slice_store_array slice_store_chk #(.N_PRI(N_PRI)) u_chk (
    .clk          (clk),
    .glob_init    (glob_init),
    .cfg_latch    (cfg_latch),
    .cfg_sync_sr  (cfg_sync_sr),
    .cfg_ck_inv   (cfg_ck_inv),
    .cfg_ce_used  (cfg_ce_used),
    .cfg_sr_used  (cfg_sr_used),
    .cfg_rst_zero (cfg_rst_zero),
    .ck_in        (ck_in),
    .ce_in        (ce_in),
    .sr_in        (sr_in),
    .d            (d),
    .q            (q)
);

// File: tb/tb_slice_store_array.sv
`timescale 1ns/1ps
module tb_slice_store_array;
    localparam int N_PRI  = 4;
    localparam int N_ELEM = 2 * N_PRI;

    logic              clk = 1'b0;
    logic              glob_init = 1'b1;
    logic              cfg_latch = 1'b0;
    logic              cfg_sync_sr = 1'b0;
    logic              cfg_ck_inv = 1'b0;
    logic              cfg_ce_used = 1'b0;
    logic              cfg_sr_used = 1'b0;
    logic [N_ELEM-1:0] cfg_init_sel = '0;
    logic [N_ELEM-1:0] cfg_rst_zero = '0;
    logic              ck_in = 1'b0;
    logic              ce_in = 1'b0;
    logic              sr_in = 1'b0;
    logic [N_ELEM-1:0] d = '0;
    logic [N_ELEM-1:0] q;

    int checks = 0;
    int fails  = 0;
    int unsigned seed = 32'h1234_5678;

    // reference state
    bit [N_ELEM-1:0] ref_q;
    bit              ref_prev;

    always #4 clk = ~clk;

    slice_store_array #(.N_PRI(N_PRI)) dut (
        .clk(clk), .glob_init(glob_init), .cfg_latch(cfg_latch),
        .cfg_sync_sr(cfg_sync_sr), .cfg_ck_inv(cfg_ck_inv),
        .cfg_ce_used(cfg_ce_used), .cfg_sr_used(cfg_sr_used),
        .cfg_init_sel(cfg_init_sel), .cfg_rst_zero(cfg_rst_zero),
        .ck_in(ck_in), .ce_in(ce_in), .sr_in(sr_in), .d(d), .q(q)
    );

    function automatic int unsigned next_rand(input int unsigned s);
        int unsigned x = s;
        x = x ^ (x << 13);
        x = x ^ (x >> 17);
        x = x ^ (x << 5);
        return x;
    endfunction

    task automatic roll(output int unsigned r);
        seed = next_rand(seed);
        r = seed;
    endtask

    task automatic check(input string tag, input logic [N_ELEM-1:0] act,
                         input logic [N_ELEM-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: q=%h expected %h", tag, act, exp);
        end
    endtask

    // One behavioural step of the reference for the current inputs
    task automatic model_step(output string tag);
        bit eff, edge_now, open_now, en, srq, nxt;
        eff      = ck_in ^ cfg_ck_inv;
        edge_now = eff && !ref_prev;
        open_now = (ck_in == cfg_ck_inv);
        en       = !cfg_ce_used || ce_in;
        srq      = cfg_sr_used && sr_in;
        for (int i = 0; i < N_ELEM; i++) begin
            nxt = ref_q[i];
            if (cfg_latch && i >= N_PRI)
                nxt = 1'b0;
            else if (glob_init)
                nxt = cfg_latch ? cfg_init_sel[i] : !cfg_init_sel[i];
            else if (cfg_latch) begin
                if (srq) nxt = !cfg_rst_zero[i];
                else if (open_now && en) nxt = d[i];
            end else if (cfg_sync_sr) begin
                if (edge_now && en) nxt = srq ? !cfg_rst_zero[i] : d[i];
            end else begin
                if (srq) nxt = !cfg_rst_zero[i];
                else if (edge_now && en) nxt = d[i];
            end
            ref_q[i] = nxt;
        end
        ref_prev = eff;
        if (glob_init)                    tag = sr_in ? "R10" : "R1";
        else if (sr_in && !cfg_sr_used)   tag = "R9";
        else if (srq)                     tag = (!cfg_latch && cfg_sync_sr) ? "R5/R7" : "R5/R6";
        else if (!ce_in)                  tag = "R8";
        else                              tag = cfg_latch ? "R3" : "R2";
    endtask

    task automatic cycle(input bit gi, input bit force_sr);
        int unsigned r;
        string tag;
        @(negedge clk);
        roll(r);
        glob_init = gi;
        if (r[1:0] == 2'd0) ck_in = ~ck_in;
        ce_in = (r[4:2] != 3'd0);
        sr_in = force_sr ? 1'b1 : (r[8:5] == 4'd0);
        d     = r[23:16];
        model_step(tag);
        @(posedge clk);
        #1;
        check(tag, q, ref_q);
        if (cfg_latch)
            check("R4", q[N_ELEM-1:N_PRI], '0);
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        checks++;
        $display("FAIL watchdog R1: finished=0 expected 1");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int unsigned r;
        ref_q    = '0;
        ref_prev = 1'b0;
        for (int m = 0; m < 32; m++) begin
            @(negedge clk);
            roll(r);
            cfg_latch    = m[0];
            cfg_sync_sr  = m[1];
            cfg_ck_inv   = m[2];
            cfg_ce_used  = m[3];
            cfg_sr_used  = m[4];
            cfg_init_sel = r[7:0];
            cfg_rst_zero = r[15:8];
            // init with set/reset also active: init must win (R10), then plain init (R1)
            cycle(1'b1, 1'b1);
            cycle(1'b1, 1'b0);
            for (int c = 0; c < 150; c++) begin
                if (c == 75) cycle(1'b1, 1'b1);
                else if (c % 37 == 5) cycle(1'b0, 1'b1);
                else cycle(1'b0, 1'b0);
            end
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule